// File: doc/BRIEF.md
# In-Order Store Queue with Atomic Read-Modify-Write Support

This block is the store side of a load/store unit. It keeps plain stores, store-conditionals and atomic read-modify-write operations in one circular buffer. Entries are allocated in program order and filled in at execute time with an address, a size and data. They are marked committed in order and then drained one at a time, from the oldest entry, to a single memory request port. The arithmetic of an atomic is done beyond that port. The queue only carries the request, and for store-conditionals and atomics it returns the response data on a register writeback output.

A load being scheduled queries the queue with its address and size. The queue answers in the same cycle with one of three outcomes:

- **Forward:** the load is fully covered by a plain store or store-conditional, and that entry's data is returned.
- **Stall:** the load overlaps an entry that cannot supply its bytes.
- **Miss:** the load may go to memory.

Atomic entries hold a slot but never supply data. An atomic whose bytes span two cache lines is flagged when it executes. It is later retired from the head without ever reaching memory.

Top module: `stq_amo`

## Requirements
- R1: After reset the queue is empty: alloc_ready is 1, alloc_idx is 0, mem_req_valid and wb_valid are 0, and any lookup returns miss.
- R2: Each accepted allocation takes the slot shown on alloc_idx, and slots are handed out in increasing order modulo DEPTH. The kind code is 0 for a store, 1 for a store-conditional and 2 for an atomic. Every kind uses a slot, and once DEPTH entries are held alloc_ready is 0.
- R3: An atomic entry ignores the execute data. Its data is zero, so its memory request carries mem_req_data equal to 0.
- R4: The lookup result code is 0 for miss, 1 for forward and 2 for stall. If the youngest executed entry that overlaps the load is a plain store or a store-conditional that covers every load byte, the result is forward. In that case lk_data holds that entry's data shifted right so that the byte at lk_addr lands in bits 7:0.
- R5: If the youngest overlapping executed entry is a plain store or a store-conditional that covers only part of the load, the result is stall.
- R6: If the youngest overlapping executed entry is an atomic, the result is stall, whether the overlap is full or partial. Forward is never taken from an atomic. The stall lasts until the entry is freed.
- R7: When several executed entries overlap the load, only the youngest one decides the result.
- R8: Entries that have not executed, and entries whose bytes do not overlap the load, are ignored, which gives miss when no other entry matters. Sizes are coded as the byte count minus one.
- R9: With 64-byte lines, an atomic crosses a line when the line index of its last byte differs from that of its first byte. A crossing atomic raises amo_cross_err in its execute cycle and never appears on the memory port. Once committed and at the head, it is freed with no request and no writeback. A non-crossing atomic that ends on the last byte of a line raises no error.
- R10: Requests come only from the head entry, and only once that entry is both executed and committed. Only one request is outstanding at a time. The request stays valid with a stable address until mem_req_ready is seen.
- R11: For a store-conditional or an atomic, wb_valid is 1 in the cycle after mem_resp_valid, with the response data on wb_data and the slot on wb_idx, and the slot is freed at the end of that cycle. A plain store is freed on the response and produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot this cycle |
| alloc_kind | input | 2 | Kind of the new entry: 0 store, 1 store-conditional, 2 atomic |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| exec_valid | input | 1 | Execute-time fill of one entry |
| exec_idx | input | IDX_W | Slot being filled |
| exec_addr | input | ADDR_W | Byte address of the access |
| exec_size | input | SZ_W | Byte count minus one |
| exec_data | input | DATA_W | Write data, ignored for atomics |
| amo_cross_err | output | 1 | Executing atomic spans two lines |
| commit_valid | input | 1 | Commit the oldest uncommitted entry |
| lk_addr | input | ADDR_W | Load byte address |
| lk_size | input | SZ_W | Load byte count minus one |
| lk_result | output | 2 | 0 miss, 1 forward, 2 stall |
| lk_data | output | DATA_W | Forwarded data, load byte 0 in bits 7:0 |
| mem_req_valid | output | 1 | Memory request from the head entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_size | output | SZ_W | Request byte count minus one |
| mem_req_data | output | DATA_W | Request data, zero for atomics |
| mem_req_kind | output | 2 | Request kind code |
| mem_resp_valid | input | 1 | Response for the outstanding request |
| mem_resp_data | input | DATA_W | Response data |
| wb_valid | output | 1 | Register writeback for a store-conditional or an atomic |
| wb_idx | output | IDX_W | Slot being written back |
| wb_data | output | DATA_W | Writeback data |

## Verification
A corrupted age pointer or overlap decision would show at once on lk_result in the same cycle as the query. Examples are the wrong entry deciding the result, a forward taken from an atomic, or a stall where a miss belongs. Mistakes in the kind or fault bits reach the memory port a few cycles after commit. They would appear as an atomic with non-zero data, a crossing atomic that is requested, or a request issued before an older entry completes. Writeback faults show in the single cycle after the response, as a missing or extra wb_valid or as the wrong wb_idx.

// File: rtl/stq_amo_pkg.sv
// Shared encodings for the store queue.
// Assumes: kind and lookup codes are fixed by the block's interface.
package stq_amo_pkg;

    typedef enum logic [1:0] {
        SQ_ST  = 2'd0,
        SQ_SC  = 2'd1,
        SQ_AMO = 2'd2
    } sq_kind_e;

    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_FWD   = 2'd1,
        LK_STALL = 2'd2
    } lk_res_e;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_WAIT = 2'd1,
        DR_WB   = 2'd2
    } drain_st_e;

endpackage

// File: rtl/stq_amo_match.sv
// Byte-range comparator between one queue entry and a load.
// Assumes: sizes are byte count minus one; ranges do not wrap the address space.
module stq_amo_match #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 3
) (
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [SZ_W-1:0]   ent_size,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    output logic              ov,
    output logic              cov
);
    localparam int PAD = ADDR_W + 1 - SZ_W;

    logic [ADDR_W:0] es, ee, ls, le;

    // Inclusive first and last byte of both ranges, one bit wider to avoid overflow.
    always_comb begin
        es  = {1'b0, ent_addr};
        ee  = es + {{PAD{1'b0}}, ent_size};
        ls  = {1'b0, ld_addr};
        le  = ls + {{PAD{1'b0}}, ld_size};
        ov  = (ls <= ee) && (es <= le);
        cov = (es <= ls) && (le <= ee);
    end
endmodule

// File: rtl/stq_amo_lookup.sv
// Load lookup: scans executed entries from oldest to youngest and lets the
// youngest overlapping one decide forward, stall or miss.
// Assumes: DEPTH is a power of two; every entry in the queue is older than the load.
module stq_amo_lookup
    import stq_amo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SZ_W  = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  head,
    input  logic [DEPTH-1:0]  e_live,
    input  logic [1:0]        e_kind [DEPTH],
    input  logic [ADDR_W-1:0] e_addr [DEPTH],
    input  logic [SZ_W-1:0]   e_size [DEPTH],
    input  logic [DATA_W-1:0] e_data [DEPTH],
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SZ_W-1:0]   lk_size,
    output logic [1:0]        lk_result,
    output logic [DATA_W-1:0] lk_data
);
    logic [DEPTH-1:0] ov, cov;
    lk_res_e          res;
    logic [IDX_W-1:0] src;

    genvar g;
    for (g = 0; g < DEPTH; g++) begin : g_match
        stq_amo_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
            .ent_addr (e_addr[g]),
            .ent_size (e_size[g]),
            .ld_addr  (lk_addr),
            .ld_size  (lk_size),
            .ov       (ov[g]),
            .cov      (cov[g])
        );
    end

    // Age-ordered scan: later (younger) hits overwrite earlier ones.
    always_comb begin
        logic [IDX_W-1:0] idx;
        res = LK_MISS;
        src = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IDX_W'(k);
            if (e_live[idx] && ov[idx]) begin
                src = idx;
                if (e_kind[idx] == SQ_AMO)  res = LK_STALL;
                else if (cov[idx])          res = LK_FWD;
                else                        res = LK_STALL;
            end
        end
    end

    // Align the forwarding entry's bytes to the load's first byte.
    always_comb begin
        if (res == LK_FWD)
            lk_data = e_data[src] >> {lk_addr[SZ_W-1:0] - e_addr[src][SZ_W-1:0], 3'b000};
        else
            lk_data = '0;
    end

    assign lk_result = res;

    // Forwarding only ever comes from a live, covering, non-atomic entry.
    assert_fwd_not_amo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res == LK_FWD) |-> (e_kind[src] != SQ_AMO) && e_live[src] && cov[src]);
endmodule

// File: rtl/stq_amo_drain.sv
// Drain engine: issues the head entry to memory, waits for its response,
// performs the register writeback for store-conditionals and atomics, and
// frees the head. Faulted atomics are freed without a request.
// Assumes: the memory port returns exactly one response per accepted request.
module stq_amo_drain
    import stq_amo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 64,
    localparam int SZ_W      = $clog2(DATA_W / 8),
    localparam int LINE_SH   = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic              head_exec,
    input  logic              head_comm,
    input  logic              head_bad,
    input  logic [1:0]        head_kind,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [SZ_W-1:0]   head_size,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic              wb_valid,
    output logic [DATA_W-1:0] wb_data,
    output logic              head_free
);
    drain_st_e         st;
    logic              head_ready;
    logic              needs_wb;
    logic [DATA_W-1:0] wb_q;

    // Head eligibility and the writeback need of its kind.
    always_comb begin
        head_ready    = head_valid && head_exec && head_comm;
        needs_wb      = (head_kind != SQ_ST);
        mem_req_valid = (st == DR_IDLE) && head_ready && !head_bad;
        head_free     = ((st == DR_IDLE) && head_ready && head_bad) ||
                        ((st == DR_WAIT) && mem_resp_valid && !needs_wb) ||
                        (st == DR_WB);
        wb_valid      = (st == DR_WB);
        wb_data       = wb_q;
    end

    // Request / response / writeback sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= DR_IDLE;
            wb_q <= '0;
        end else begin
            case (st)
                DR_IDLE: if (mem_req_valid && mem_req_ready) st <= DR_WAIT;
                DR_WAIT: if (mem_resp_valid) begin
                    if (needs_wb) begin
                        wb_q <= mem_resp_data;
                        st   <= DR_WB;
                    end else begin
                        st   <= DR_IDLE;
                    end
                end
                default: st <= DR_IDLE;
            endcase
        end
    end

    // A request waiting for acceptance holds its address.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(head_addr));

    // No new request while one is outstanding.
    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != DR_IDLE) |-> !mem_req_valid);

    // An atomic spanning two lines never reaches the port.
    assert_no_cross_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && head_kind == SQ_AMO) |->
        ((({1'b0, head_addr} + {{(ADDR_W + 1 - SZ_W){1'b0}}, head_size}) >> LINE_SH) ==
         ({1'b0, head_addr} >> LINE_SH)));
endmodule

// File: rtl/stq_amo.sv
// Store queue top: circular entry storage with allocate, execute and commit
// updates, the load lookup and the in-order drain engine.
// Assumes: DEPTH is a power of two; execute and commit target allocated entries;
// an entry is not allocated and executed in the same cycle.
module stq_amo
    import stq_amo_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 64,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int SZ_W      = $clog2(DATA_W / 8),
    localparam int LINE_SH   = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              exec_valid,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic [SZ_W-1:0]   exec_size,
    input  logic [DATA_W-1:0] exec_data,
    output logic              amo_cross_err,
    input  logic              commit_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SZ_W-1:0]   lk_size,
    output logic [1:0]        lk_result,
    output logic [DATA_W-1:0] lk_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [SZ_W-1:0]   mem_req_size,
    output logic [DATA_W-1:0] mem_req_data,
    output logic [1:0]        mem_req_kind,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    logic [DEPTH-1:0]  e_valid, e_exec, e_comm, e_bad;
    logic [1:0]        e_kind [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [SZ_W-1:0]   e_size [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];

    logic [IDX_W-1:0]  head, tail, cmt;
    logic [CNT_W-1:0]  cnt;
    logic              alloc_fire, exec_ok, exec_is_amo, exec_cross, commit_fire, head_free;

    // Handshake qualifiers and the line-crossing test on the executing access.
    always_comb begin
        alloc_ready   = (cnt != CNT_W'(DEPTH));
        alloc_fire    = alloc_valid && alloc_ready;
        exec_ok       = exec_valid && e_valid[exec_idx];
        exec_is_amo   = (e_kind[exec_idx] == SQ_AMO);
        exec_cross    = ((({1'b0, exec_addr} + {{(ADDR_W + 1 - SZ_W){1'b0}}, exec_size}) >> LINE_SH) !=
                         ({1'b0, exec_addr} >> LINE_SH));
        amo_cross_err = exec_ok && exec_is_amo && exec_cross;
        commit_fire   = commit_valid && e_valid[cmt] && !e_comm[cmt];
    end

    // Entry status bits: allocate, execute, commit and free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_exec  <= '0;
            e_comm  <= '0;
            e_bad   <= '0;
        end else begin
            if (head_free) e_valid[head] <= 1'b0;
            if (alloc_fire) begin
                e_valid[tail] <= 1'b1;
                e_exec[tail]  <= 1'b0;
                e_comm[tail]  <= 1'b0;
                e_bad[tail]   <= 1'b0;
            end
            if (exec_ok) begin
                e_exec[exec_idx] <= 1'b1;
                if (exec_is_amo && exec_cross) e_bad[exec_idx] <= 1'b1;
            end
            if (commit_fire) e_comm[cmt] <= 1'b1;
        end
    end

    // Entry payload: kind at allocate, address/size/data at execute (atomics keep zero data).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                e_kind[i] <= SQ_ST;
                e_addr[i] <= '0;
                e_size[i] <= '0;
                e_data[i] <= '0;
            end
        end else begin
            if (alloc_fire) begin
                e_kind[tail] <= alloc_kind;
                e_data[tail] <= '0;
            end
            if (exec_ok) begin
                e_addr[exec_idx] <= exec_addr;
                e_size[exec_idx] <= exec_size;
                if (!exec_is_amo) e_data[exec_idx] <= exec_data;
            end
        end
    end

    // Head, tail, commit pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cmt  <= '0;
            cnt  <= '0;
        end else begin
            if (alloc_fire)  tail <= tail + 1'b1;
            if (head_free)   head <= head + 1'b1;
            if (commit_fire) cmt  <= cmt + 1'b1;
            case ({alloc_fire, head_free})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign alloc_idx    = tail;
    assign mem_req_addr = e_addr[head];
    assign mem_req_size = e_size[head];
    assign mem_req_data = e_data[head];
    assign mem_req_kind = e_kind[head];
    assign wb_idx       = head;

    stq_amo_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head),
        .e_live    (e_valid & e_exec),
        .e_kind    (e_kind),
        .e_addr    (e_addr),
        .e_size    (e_size),
        .e_data    (e_data),
        .lk_addr   (lk_addr),
        .lk_size   (lk_size),
        .lk_result (lk_result),
        .lk_data   (lk_data)
    );

    stq_amo_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_drain (
        .clk            (clk),
        .rst_n          (rst_n),
        .head_valid     (e_valid[head]),
        .head_exec      (e_exec[head]),
        .head_comm      (e_comm[head]),
        .head_bad       (e_bad[head]),
        .head_kind      (e_kind[head]),
        .head_addr      (e_addr[head]),
        .head_size      (e_size[head]),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .wb_valid       (wb_valid),
        .wb_data        (wb_data),
        .head_free      (head_free)
    );

    // Occupancy never exceeds the slot count.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // Writeback only for a live store-conditional or atomic at the head.
    assert_wb_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> e_valid[head] && (e_kind[head] != SQ_ST));

    // A request always comes from a committed, executed head.
    assert_req_from_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> e_valid[head] && e_exec[head] && e_comm[head]);
endmodule

// File: tb/stq_amo_test.sv
`timescale 1ns/100ps
module stq_amo_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid;
    logic [1:0]  alloc_kind;
    logic        alloc_ready;
    logic [2:0]  alloc_idx;
    logic        exec_valid;
    logic [2:0]  exec_idx;
    logic [31:0] exec_addr;
    logic [2:0]  exec_size;
    logic [63:0] exec_data;
    logic        amo_cross_err;
    logic        commit_valid;
    logic [31:0] lk_addr;
    logic [2:0]  lk_size;
    logic [1:0]  lk_result;
    logic [63:0] lk_data;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic [2:0]  mem_req_size;
    logic [63:0] mem_req_data;
    logic [1:0]  mem_req_kind;
    logic        mem_resp_valid;
    logic [63:0] mem_resp_data;
    logic        wb_valid;
    logic [2:0]  wb_idx;
    logic [63:0] wb_data;

    int checks = 0;
    int fails  = 0;

    localparam logic [1:0] K_ST = 2'd0, K_SC = 2'd1, K_AMO = 2'd2;
    localparam logic [1:0] R_MISS = 2'd0, R_FWD = 2'd1, R_STALL = 2'd2;

    always #2.5 clk = ~clk;

    stq_amo uut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_valid = 0; alloc_kind = 0; exec_valid = 0; exec_idx = 0;
        exec_addr = 0; exec_size = 0; exec_data = 0; commit_valid = 0;
        lk_addr = 32'hFFFF_0000; lk_size = 0; mem_req_ready = 0;
        mem_resp_valid = 0; mem_resp_data = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_alloc(input logic [1:0] k, input logic [2:0] exp_idx, input string tag);
        alloc_valid = 1'b1;
        alloc_kind  = k;
        #0.5;
        chk(tag, 64'(alloc_idx), 64'(exp_idx));
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic do_exec(input logic [2:0] idx, input logic [31:0] a, input logic [2:0] sz,
                           input logic [63:0] d);
        exec_valid = 1'b1; exec_idx = idx; exec_addr = a; exec_size = sz; exec_data = d;
        tick();
        exec_valid = 1'b0;
    endtask

    task automatic do_commit();
        commit_valid = 1'b1;
        tick();
        commit_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [2:0] sz, input logic [1:0] er,
                          input logic [63:0] ed, input string tag);
        lk_addr = a;
        lk_size = sz;
        #0.5;
        chk({tag, " result"}, 64'(lk_result), 64'(er));
        if (er == R_FWD) chk({tag, " data"}, lk_data, ed);
        lk_addr = 32'hFFFF_0000;
        lk_size = 0;
    endtask

    // Accept one request, check it, respond, and check the writeback behaviour.
    task automatic serve(input logic [31:0] ea, input logic [63:0] ed, input logic [1:0] ek,
                         input logic [63:0] rd, input bit wbx, input logic [2:0] widx,
                         input string tag);
        for (int n = 0; n < 20; n++) begin
            if (mem_req_valid) break;
            tick();
        end
        chk({tag, " R10 req valid"}, 64'(mem_req_valid), 64'd1);
        chk({tag, " req addr"}, 64'(mem_req_addr), 64'(ea));
        chk({tag, " req data"}, mem_req_data, ed);
        chk({tag, " req kind"}, 64'(mem_req_kind), 64'(ek));
        mem_req_ready = 1'b1;
        tick();
        mem_req_ready = 1'b0;
        #0.5;
        chk({tag, " R10 single outstanding"}, 64'(mem_req_valid), 64'd0);
        mem_resp_valid = 1'b1;
        mem_resp_data  = rd;
        tick();
        mem_resp_valid = 1'b0;
        #0.5;
        chk({tag, " R11 wb_valid"}, 64'(wb_valid), 64'(wbx));
        if (wbx) begin
            chk({tag, " R11 wb_data"}, wb_data, rd);
            chk({tag, " R11 wb_idx"}, 64'(wb_idx), 64'(widx));
        end
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1 alloc_idx", 64'(alloc_idx), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1 wb_valid", 64'(wb_valid), 64'd0);
        lookup(32'h100, 3'd7, R_MISS, 64'd0, "R1 empty lookup");
    endtask

    task automatic t_fill();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            do_alloc(2'(i % 3), 3'(i), "R2 alloc order");
            if (i < 7) chk("R2 ready before full", 64'(alloc_ready), 64'd1);
        end
        chk("R2 full with atomics", 64'(alloc_ready), 64'd0);
        lookup(32'h0, 3'd7, R_MISS, 64'd0, "R8 unexecuted ignored");
    endtask

    task automatic t_forward();
        do_reset();
        do_alloc(K_ST, 3'd0, "R2 idx0");
        do_alloc(K_ST, 3'd1, "R2 idx1");
        do_exec(3'd0, 32'h100, 3'd7, 64'h8877_6655_4433_2211);
        lookup(32'h102, 3'd1, R_FWD, 64'h0000_8877_6655_4433, "R4 covered fwd");
        lookup(32'h106, 3'd3, R_STALL, 64'd0, "R5 partial plain");
        lookup(32'h200, 3'd3, R_MISS, 64'd0, "R8 no overlap");
        lookup(32'h0F8, 3'd7, R_MISS, 64'd0, "R8 adjacent below");
    endtask

    task automatic t_atomic();
        do_reset();
        do_alloc(K_AMO, 3'd0, "R2 amo idx");
        do_exec(3'd0, 32'h300, 3'd3, 64'hDEAD_BEEF_CAFE_F00D);
        lookup(32'h300, 3'd3, R_STALL, 64'd0, "R6 full amo overlap");
        lookup(32'h302, 3'd3, R_STALL, 64'd0, "R6 partial amo overlap");
        tick();
        #0.5;
        chk("R10 no req before commit", 64'(mem_req_valid), 64'd0);
        do_commit();
        serve(32'h300, 64'd0, K_AMO, 64'h1234, 1'b1, 3'd0, "R3 amo zero data");
        lookup(32'h300, 3'd3, R_MISS, 64'd0, "R6 stall ends after free");
    endtask

    task automatic t_youngest();
        do_reset();
        do_alloc(K_ST, 3'd0, "R2 y0");
        do_alloc(K_ST, 3'd1, "R2 y1");
        do_exec(3'd0, 32'h400, 3'd7, 64'h0807_0605_0403_0201);
        do_exec(3'd1, 32'h404, 3'd3, 64'h0000_0000_DDCC_BBAA);
        lookup(32'h404, 3'd3, R_FWD, 64'h0000_0000_DDCC_BBAA, "R7 younger store wins");
        lookup(32'h400, 3'd1, R_FWD, 64'h0807_0605_0403_0201, "R7 only older overlaps");
        lookup(32'h403, 3'd1, R_STALL, 64'd0, "R7 R5 younger partial");
        do_alloc(K_AMO, 3'd2, "R2 y2");
        do_exec(3'd2, 32'h400, 3'd3, 64'h5555);
        lookup(32'h404, 3'd3, R_FWD, 64'h0000_0000_DDCC_BBAA, "R7 amo not overlapping");
        lookup(32'h402, 3'd1, R_STALL, 64'd0, "R7 R6 youngest is amo");
        do_reset();
        do_alloc(K_AMO, 3'd0, "R2 z0");
        do_alloc(K_ST, 3'd1, "R2 z1");
        do_exec(3'd0, 32'h500, 3'd3, 64'h0);
        do_exec(3'd1, 32'h500, 3'd3, 64'h1122_3344);
        lookup(32'h501, 3'd1, R_FWD, 64'h0011_2233, "R7 store younger than amo");
    endtask

    task automatic t_cross();
        do_reset();
        do_alloc(K_AMO, 3'd0, "R2 c0");
        do_alloc(K_AMO, 3'd1, "R2 c1");
        do_alloc(K_ST,  3'd2, "R2 c2");
        exec_valid = 1; exec_idx = 3'd0; exec_addr = 32'h3C; exec_size = 3'd7; exec_data = 64'h77;
        #0.5;
        chk("R9 crossing flagged", 64'(amo_cross_err), 64'd1);
        tick();
        exec_valid = 1; exec_idx = 3'd1; exec_addr = 32'h38; exec_size = 3'd7; exec_data = 64'h66;
        #0.5;
        chk("R9 line end not flagged", 64'(amo_cross_err), 64'd0);
        tick();
        exec_valid = 0;
        do_exec(3'd2, 32'h80, 3'd3, 64'hA5A5);
        do_commit();
        do_commit();
        do_commit();
        serve(32'h38, 64'd0, K_AMO, 64'hAB, 1'b1, 3'd1, "R9 crossing dropped, next issued");
        serve(32'h80, 64'hA5A5, K_ST, 64'h0, 1'b0, 3'd0, "R9 trailing store");
    endtask

    task automatic t_order();
        do_reset();
        do_alloc(K_ST, 3'd0, "R2 o0");
        do_alloc(K_SC, 3'd1, "R2 o1");
        do_exec(3'd1, 32'h608, 3'd7, 64'hEEEE);
        do_commit();
        do_commit();
        tick();
        #0.5;
        chk("R10 head not executed blocks", 64'(mem_req_valid), 64'd0);
        do_exec(3'd0, 32'h600, 3'd7, 64'hD00D);
        #0.5;
        chk("R10 hold valid 1", 64'(mem_req_valid), 64'd1);
        chk("R10 head first", 64'(mem_req_addr), 64'h600);
        tick();
        #0.5;
        chk("R10 hold valid 2", 64'(mem_req_valid), 64'd1);
        chk("R10 hold addr", 64'(mem_req_addr), 64'h600);
        serve(32'h600, 64'hD00D, K_ST, 64'h0, 1'b0, 3'd0, "R11 plain no wb");
        serve(32'h608, 64'hEEEE, K_SC, 64'h1, 1'b1, 3'd1, "R11 sc wb");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_forward();
        t_atomic();
        t_youngest();
        t_cross();
        t_order();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule